// File: doc/BRIEF.md
# Block variance accumulator

This block measures how well a candidate block of pixels matches a reference block. For every pixel it takes the signed difference, candidate minus reference. Over the whole block it keeps two running totals: the signed sum of these differences and the unsigned sum of their squares (SSE). When the block is complete, it reports the SSE, the signed sum, and a variance figure. The variance is the SSE minus the squared sum scaled down by the pixel count, with the scaling done as a right shift.

A start pulse arms the block. The same pulse selects one of five block shapes and chooses between variance mode and plain-SSE (MSE) mode. Pixels then arrive as beats of `LANES` candidate/reference pairs, qualified by a valid strobe, in raster order. Cycles with valid low simply stall the count. After the final beat, the results are registered and a one-cycle done pulse is raised. The results then hold until the next block finishes.

Top module: `block_var_acc`

## Requirements
- R1: Each lane difference is candidate minus reference as a signed 9-bit value, and `sum_o` reports the signed total of all differences in the block.
- R2: `sse_o` reports the total of the squared lane differences over the block, as an unsigned 32-bit value.
- R3: In variance mode, `var_o` equals `sse_o - ((sum*sum) >> S)`. The shape code on `size_i` fixes S: 0 = 16x16 (S=8), 1 = 32x16 (S=9), 2 = 32x32 (S=10), 3 = 64x32 (S=11), 4 = 64x64 (S=12).
- R4: The product sum*sum is formed at 64-bit width before the shift, and the difference is truncated to 32 bits. For example, a 64x64 block with every candidate 255 and every reference 0 gives sum 1044480, SSE 266342400 and variance 0.
- R5: When `mse_i` is high at start, `var_o` reports the SSE with no mean correction.
- R6: A start pulse clears both totals and restarts the count, even in the middle of a block. A beat that is valid in the same cycle as start is discarded.
- R7: Valid beats that arrive while no block is armed leave the totals and the outputs untouched.
- R8: If the last beat of a block is sampled at clock edge k, `done_o` and the new results appear at edge k+1, and `done_o` falls at edge k+2.
- R9: `sse_o`, `sum_o` and `var_o` hold their values between done pulses.
- R10: A block takes W*H/LANES valid beats. Lane i occupies bits [8i+7:8i] of `src_i` and `ref_i`. Cycles with valid low do not count.
- R11: The unused shape codes 5, 6 and 7 behave as 16x16.
- R12: After reset, `done_o` is low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new block and clears the totals |
| size_i | input | 3 | Block shape code, sampled with start |
| mse_i | input | 1 | MSE mode select, sampled with start |
| valid_i | input | 1 | Beat qualifier |
| src_i | input | 8*LANES | Candidate pixels, one byte per lane |
| ref_i | input | 8*LANES | Reference pixels, one byte per lane |
| done_o | output | 1 | One-cycle completion pulse |
| sse_o | output | 32 | Sum of squared differences |
| sum_o | output | 21 | Signed sum of differences |
| var_o | output | 32 | Variance, or SSE in MSE mode |

## Verification
The bench targets the saturated 64x64 block, in both polarities. A design that squares the sum at 32 bits would report a large spurious variance there, and one that keeps the sum too narrow would flip its sign. A ramp of lane-dependent differences tests lane ordering and the 16x16 shift against a closed-form result. The same ramp is used with an unused shape code, which would never finish if that code were taken as a larger block, and in MSE mode, which would subtract the mean correction if the mode latch were ignored. The bench also issues a restart in the middle of a block with a beat in the same cycle, feeds stray beats while idle, and leaves valid gaps inside a block. A design that fails to discard or stall these beats ends up with totals that differ from the cycle-by-cycle model.

// File: rtl/vacc_pkg.sv
package vacc_pkg;
  localparam int PIX_W     = 8;
  localparam int DIFF_W    = PIX_W + 1;
  localparam int SQ_W      = 2 * PIX_W;
  localparam int MIN_SHIFT = 8;
  localparam int MAX_SHIFT = 12;
  localparam int SHIFT_W   = 4;
  localparam int SSE_W     = 32;
  localparam int SUM_W     = MAX_SHIFT + PIX_W + 1;
  localparam int PROD_W    = 64;

  typedef enum logic [2:0] {
    SZ_16X16 = 3'd0,
    SZ_32X16 = 3'd1,
    SZ_32X32 = 3'd2,
    SZ_64X32 = 3'd3,
    SZ_64X64 = 3'd4
  } blk_size_e;

  // log2 of the pixel count for a shape code; spare codes act as 16x16
  function automatic logic [SHIFT_W-1:0] size_to_shift(input logic [2:0] code);
    case (code)
      SZ_16X16: size_to_shift = SHIFT_W'(MIN_SHIFT);
      SZ_32X16: size_to_shift = SHIFT_W'(MIN_SHIFT + 1);
      SZ_32X32: size_to_shift = SHIFT_W'(MIN_SHIFT + 2);
      SZ_64X32: size_to_shift = SHIFT_W'(MIN_SHIFT + 3);
      SZ_64X64: size_to_shift = SHIFT_W'(MIN_SHIFT + 4);
      default:  size_to_shift = SHIFT_W'(MIN_SHIFT);
    endcase
  endfunction

  function automatic logic signed [DIFF_W-1:0] pix_diff(input logic [PIX_W-1:0] s,
                                                        input logic [PIX_W-1:0] r);
    pix_diff = $signed({1'b0, s}) - $signed({1'b0, r});
  endfunction

  function automatic logic [SQ_W-1:0] diff_sq(input logic signed [DIFF_W-1:0] d);
    logic signed [DIFF_W-1:0] nd;
    logic [PIX_W-1:0]         mag;
    nd  = -d;
    mag = d[DIFF_W-1] ? nd[PIX_W-1:0] : d[PIX_W-1:0];
    diff_sq = SQ_W'(mag) * SQ_W'(mag);
  endfunction

  function automatic logic [SSE_W-1:0] mean_corrected(input logic [SSE_W-1:0]        sse,
                                                      input logic signed [SUM_W-1:0] sum,
                                                      input logic [SHIFT_W-1:0]      shift,
                                                      input logic                    mse);
    logic signed [PROD_W-1:0] s64;
    logic [PROD_W-1:0]        sq;
    logic [PROD_W-1:0]        scaled;
    s64    = {{(PROD_W-SUM_W){sum[SUM_W-1]}}, sum};
    sq     = s64 * s64;
    scaled = sq >> shift;
    mean_corrected = mse ? sse : (sse - scaled[SSE_W-1:0]);
  endfunction
endpackage

// File: rtl/vacc_lane_math.sv
module vacc_lane_math
  import vacc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int LG_L  = $clog2(LANES),
  parameter int BS_W  = DIFF_W + LG_L,
  parameter int BQ_W  = SQ_W + LG_L
) (
  input  logic [LANES*PIX_W-1:0] src_i,
  input  logic [LANES*PIX_W-1:0] ref_i,
  output logic signed [BS_W-1:0] beat_sum_o,
  output logic [BQ_W-1:0]        beat_sse_o
);
  logic signed [DIFF_W-1:0] lane_diff [LANES];
  logic [SQ_W-1:0]          lane_sq   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_diff[g] = pix_diff(src_i[g*PIX_W +: PIX_W], ref_i[g*PIX_W +: PIX_W]);
    assign lane_sq[g]   = diff_sq(lane_diff[g]);
  end

  always_comb begin
    beat_sum_o = '0;
    beat_sse_o = '0;
    for (int i = 0; i < LANES; i++) begin
      beat_sum_o = beat_sum_o + {{(BS_W-DIFF_W){lane_diff[i][DIFF_W-1]}}, lane_diff[i]};
      beat_sse_o = beat_sse_o + BQ_W'(lane_sq[i]);
    end
  end
endmodule

// File: rtl/vacc_ctrl.sv
module vacc_ctrl
  import vacc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int LG_L  = $clog2(LANES),
  parameter int CNT_W = MAX_SHIFT - LG_L + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         size_i,
  input  logic               mse_i,
  input  logic               valid_i,
  output logic               clear_o,
  output logic               accept_o,
  output logic               fin_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               mse_o
);
  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   beats_m1;
  logic [SHIFT_W-1:0] shift_q;
  logic               mse_q;
  logic               fin_q;
  logic               last_beat;

  always_comb begin
    int exp_w;
    exp_w    = int'(shift_q) - LG_L;
    beats_m1 = (CNT_W'(1) << exp_w) - CNT_W'(1);
  end

  assign clear_o   = start_i;
  assign accept_o  = busy_q && valid_i && !start_i;
  assign last_beat = accept_o && (cnt_q == beats_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= SHIFT_W'(MIN_SHIFT);
      mse_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= last_beat;
      if (start_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        shift_q <= size_to_shift(size_i);
        mse_q   <= mse_i;
      end else if (accept_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (last_beat) busy_q <= 1'b0;
      end
    end
  end

  assign fin_o   = fin_q;
  assign shift_o = shift_q;
  assign mse_o   = mse_q;

  // R10
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= beats_m1));
  // R8
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (fin_q && !busy_q));
endmodule

// File: rtl/vacc_accum.sv
module vacc_accum
  import vacc_pkg::*;
#(
  parameter int BS_W = 13,
  parameter int BQ_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    accept_i,
  input  logic signed [BS_W-1:0]  beat_sum_i,
  input  logic [BQ_W-1:0]         beat_sse_i,
  output logic signed [SUM_W-1:0] acc_sum_o,
  output logic [SSE_W-1:0]        acc_sse_o
);
  logic signed [SUM_W-1:0] sum_q;
  logic [SSE_W-1:0]        sse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sse_q <= '0;
    end else if (clear_i) begin
      sum_q <= '0;
      sse_q <= '0;
    end else if (accept_i) begin
      sum_q <= sum_q + {{(SUM_W-BS_W){beat_sum_i[BS_W-1]}}, beat_sum_i};
      sse_q <= sse_q + SSE_W'(beat_sse_i);
    end
  end

  assign acc_sum_o = sum_q;
  assign acc_sse_o = sse_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !clear_i) |=> ($stable(sse_q) && $stable(sum_q)));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sse_q == '0 && sum_q == '0));
endmodule

// File: rtl/vacc_result.sv
module vacc_result
  import vacc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fin_i,
  input  logic signed [SUM_W-1:0] acc_sum_i,
  input  logic [SSE_W-1:0]        acc_sse_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    mse_i,
  output logic                    done_o,
  output logic [SSE_W-1:0]        sse_o,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [SSE_W-1:0]        var_o
);
  logic                    done_q;
  logic [SSE_W-1:0]        sse_q;
  logic signed [SUM_W-1:0] sum_q;
  logic [SSE_W-1:0]        var_q;
  logic                    mse_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      sse_q     <= '0;
      sum_q     <= '0;
      var_q     <= '0;
      mse_out_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) begin
        sse_q     <= acc_sse_i;
        sum_q     <= acc_sum_i;
        var_q     <= mean_corrected(acc_sse_i, acc_sum_i, shift_i, mse_i);
        mse_out_q <= mse_i;
      end
    end
  end

  assign done_o = done_q;
  assign sse_o  = sse_q;
  assign sum_o  = sum_q;
  assign var_o  = var_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> ($stable(sse_q) && $stable(sum_q) && $stable(var_q)));
  // R3
  var_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (var_q <= sse_q));
  // R5
  mse_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mse_out_q) |-> (var_q == sse_q));
endmodule

// File: rtl/block_var_acc.sv
module block_var_acc
  import vacc_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [2:0]              size_i,
  input  logic                    mse_i,
  input  logic                    valid_i,
  input  logic [LANES*PIX_W-1:0]  src_i,
  input  logic [LANES*PIX_W-1:0]  ref_i,
  output logic                    done_o,
  output logic [SSE_W-1:0]        sse_o,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [SSE_W-1:0]        var_o
);
  localparam int LG_L = $clog2(LANES);
  localparam int BS_W = DIFF_W + LG_L;
  localparam int BQ_W = SQ_W + LG_L;

  logic signed [BS_W-1:0]  beat_sum;
  logic [BQ_W-1:0]         beat_sse;
  logic                    clear;
  logic                    accept;
  logic                    fin;
  logic [SHIFT_W-1:0]      shift;
  logic                    mse_mode;
  logic signed [SUM_W-1:0] acc_sum;
  logic [SSE_W-1:0]        acc_sse;

  vacc_lane_math #(.LANES(LANES), .LG_L(LG_L), .BS_W(BS_W), .BQ_W(BQ_W)) u_math (
    .src_i      (src_i),
    .ref_i      (ref_i),
    .beat_sum_o (beat_sum),
    .beat_sse_o (beat_sse)
  );

  vacc_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .size_i   (size_i),
    .mse_i    (mse_i),
    .valid_i  (valid_i),
    .clear_o  (clear),
    .accept_o (accept),
    .fin_o    (fin),
    .shift_o  (shift),
    .mse_o    (mse_mode)
  );

  vacc_accum #(.BS_W(BS_W), .BQ_W(BQ_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .accept_i   (accept),
    .beat_sum_i (beat_sum),
    .beat_sse_i (beat_sse),
    .acc_sum_o  (acc_sum),
    .acc_sse_o  (acc_sse)
  );

  vacc_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_i     (fin),
    .acc_sum_i (acc_sum),
    .acc_sse_i (acc_sse),
    .shift_i   (shift),
    .mse_i     (mse_mode),
    .done_o    (done_o),
    .sse_o     (sse_o),
    .sum_o     (sum_o),
    .var_o     (var_o)
  );
endmodule

// File: tb/block_var_acc_tb.sv
module block_var_acc_tb;
  import vacc_pkg::*;
  localparam int LANES = 16;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] size_i = 3'd0;
  logic mse_i = 1'b0;
  logic valid_i = 1'b0;
  logic [LANES*8-1:0] src_i = '0;
  logic [LANES*8-1:0] ref_i = '0;
  logic done_o;
  logic [31:0] sse_o;
  logic signed [SUM_W-1:0] sum_o;
  logic [31:0] var_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  block_var_acc #(.LANES(LANES)) u_dut (.*);

  // reference model state
  bit m_busy = 0, m_fin = 0, m_mse = 0;
  int m_cnt = 0, m_beats = 0, m_sh = 8;
  longint m_sse = 0, m_sum = 0;
  bit e_done = 0;
  longint e_sse = 0, e_sum = 0, e_var = 0;

  function automatic int shape_shift(int code);
    if (code >= 0 && code <= 4) return 8 + code;
    return 8;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_fin = 0; m_cnt = 0; m_sse = 0; m_sum = 0;
      e_done = 0; e_sse = 0; e_sum = 0; e_var = 0;
    end else begin
      e_done = m_fin;
      if (m_fin) begin
        e_sse = m_sse;
        e_sum = m_sum;
        if (m_mse) e_var = m_sse;
        else e_var = (m_sse - ((m_sum * m_sum) >> m_sh)) & 64'hFFFF_FFFF;
      end
      m_fin = 0;
      if (start_i) begin
        m_busy = 1; m_cnt = 0; m_sse = 0; m_sum = 0;
        m_sh = shape_shift(int'(size_i));
        m_beats = (1 << m_sh) / LANES;
        m_mse = mse_i;
      end else if (m_busy && valid_i) begin
        for (int i = 0; i < LANES; i++) begin
          int d;
          d = int'(src_i[i*8 +: 8]) - int'(ref_i[i*8 +: 8]);
          m_sum += d;
          m_sse += d * d;
        end
        m_cnt++;
        if (m_cnt == m_beats) begin
          m_busy = 0;
          m_fin = 1;
        end
      end
    end
  end

  task automatic check(string tag, longint act, longint exp_v, string what);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp_v, cycles);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8", longint'(done_o), longint'(e_done), "done");
      check("R2", longint'(sse_o), e_sse, "sse");
      check("R1", longint'(sum_o), e_sum, "sum");
      check("R3", longint'(var_o), e_var, "var");
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  function automatic int beats_of(int code);
    return (1 << shape_shift(code)) / LANES;
  endfunction

  task automatic do_start(int code, bit mse, bit with_beat);
    start_i = 1; size_i = 3'(code); mse_i = mse;
    valid_i = with_beat;
    src_i = {LANES{8'hC3}}; ref_i = '0;
    @(negedge clk);
    start_i = 0; valid_i = 0;
  endtask

  // pat: 0 random, 1 equal, 2 src 255 ref 0, 3 src 0 ref 255, 4 random with gaps, 5 ramp
  task automatic feed(int nbeats, int pat);
    for (int b = 0; b < nbeats; b++) begin
      if (pat == 4 && (b % 3 == 1)) begin
        valid_i = 0;
        src_i = {LANES{8'hFF}};
        @(negedge clk);
      end
      for (int i = 0; i < LANES; i++) begin
        case (pat)
          1: begin src_i[i*8 +: 8] = 8'($urandom); ref_i[i*8 +: 8] = src_i[i*8 +: 8]; end
          2: begin src_i[i*8 +: 8] = 8'd255; ref_i[i*8 +: 8] = 8'd0; end
          3: begin src_i[i*8 +: 8] = 8'd0; ref_i[i*8 +: 8] = 8'd255; end
          5: begin src_i[i*8 +: 8] = 8'(100 + i); ref_i[i*8 +: 8] = 8'd100; end
          default: begin src_i[i*8 +: 8] = 8'($urandom); ref_i[i*8 +: 8] = 8'($urandom); end
        endcase
      end
      valid_i = 1;
      @(negedge clk);
    end
    valid_i = 0;
  endtask

  task automatic run_block(int code, bit mse, int pat);
    do_start(code, mse, 0);
    feed(beats_of(code), pat);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", longint'(done_o), 0, "done in reset");
    check("R12", longint'(sse_o) + longint'(var_o), 0, "results in reset");
    rst_n = 1;
    @(negedge clk);

    // R7 stray beats while idle
    feed(5, 0);
    @(negedge clk);
    check("R7", longint'(sse_o), 0, "sse after idle beats");
    check("R7", longint'(sum_o), 0, "sum after idle beats");

    // R1 R2 zero-difference block
    run_block(0, 0, 1);
    check("R2", longint'(sse_o), 0, "equal block sse");
    check("R1", longint'(sum_o), 0, "equal block sum");

    // R10 lane ordering with ramp on 16x16: sum 1920, sse 19840, var 5440
    run_block(0, 0, 5);
    check("R10", longint'(sum_o), 1920, "ramp sum");
    check("R10", longint'(sse_o), 19840, "ramp sse");
    check("R3", longint'(var_o), 5440, "ramp var");

    // R5 MSE mode
    run_block(0, 1, 5);
    check("R5", longint'(var_o), 19840, "mse var");

    // R11 spare code acts as 16x16
    run_block(6, 0, 5);
    check("R11", longint'(var_o), 5440, "spare code var");
    check("R11", longint'(sse_o), 19840, "spare code sse");

    // R3 every shape, random data, with and without gaps
    for (int c = 0; c < 5; c++) run_block(c, 0, (c % 2 == 0) ? 0 : 4);

    // R4 saturated 64x64, both polarities
    run_block(4, 0, 2);
    check("R4", longint'(sum_o), 1044480, "sat sum");
    check("R4", longint'(sse_o), 266342400, "sat sse");
    check("R4", longint'(var_o), 0, "sat var");
    run_block(4, 0, 3);
    check("R4", longint'(sum_o), -1044480, "neg sat sum");
    check("R4", longint'(var_o), 0, "neg sat var");

    // R6 restart mid-block with a beat in the start cycle
    do_start(4, 0, 0);
    feed(10, 0);
    do_start(0, 0, 1);
    feed(beats_of(0), 5);
    repeat (2) @(negedge clk);
    check("R6", longint'(sum_o), 1920, "restart sum");
    check("R6", longint'(var_o), 5440, "restart var");

    // R9 hold after done
    repeat (5) @(negedge clk);
    check("R9", longint'(sse_o), 19840, "held sse");
    check("R8", longint'(done_o), 0, "done low while idle");

    finish_run();
  end
endmodule